// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the bytes of one page write and later copies them into a storage array during a single self-timed program cycle. A write transaction opens with an address: its upper bits select the page, and its low six bits give the first in-page offset. Each data byte that follows lands at the current offset, which then steps forward inside the 64-byte page. Only the low six bits advance, so the stream wraps around to the start of the page.

A commit request starts the program cycle, but only when at least one byte has been loaded. The block then raises `busy_o` for a fixed number of system clocks. During the first 64 of those clocks it walks the page offsets in ascending order. For each offset that was loaded in this transaction, it issues one write on a plain synchronous array write port.

While `busy_o` is high, every request is ignored. This mirrors a device that stays deaf on its bus while programming. The loaded-byte record is wiped when a program cycle ends and whenever a new transaction opens.

Top module: `page_commit_buffer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy_o` and `arr_we_o` are low.
- R2: An accepted open request takes the page from `open_addr_i[ADDR_W-1:6]` and the starting offset from `open_addr_i[5:0]`, and it discards every byte loaded before it.
- R3: Each accepted load stores `load_data_i` at the current offset and then advances the offset by one, modulo 64. The page number does not change.
- R4: When more than 64 bytes are loaded in one transaction, the offset wraps, and a later byte replaces the earlier byte at the same offset.
- R5: An accepted commit with at least one byte loaded raises `busy_o` in the cycle after the request. `busy_o` then stays high for exactly `PROG_CYCLES` cycles.
- R6: During a program cycle, busy cycle k (counting from 0, with k < 64) carries one array write for offset k exactly when that offset was loaded. The write address is {page, k} and the data is the byte stored there. No other array writes occur.
- R7: A commit request made while no byte is loaded starts nothing: `busy_o` stays low and no array write occurs.
- R8: The loaded-byte record is empty once a program cycle ends, so a second commit with no new loads starts nothing.
- R9: Open, load and commit requests that arrive while `busy_o` is high have no effect. The page, the offset and the loaded bytes are left unchanged.
- R10: When requests coincide while idle, only one is honoured, with priority open, then commit, then load. A commit made with nothing loaded still takes precedence over a load in the same cycle, and that load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| open_i | input | 1 | Open a new page write transaction |
| open_addr_i | input | ADDR_W | Start address: page in the upper bits, offset in the low 6 bits |
| load_i | input | 1 | Load one data byte at the current offset |
| load_data_i | input | 8 | Data byte to load |
| commit_i | input | 1 | Request the program cycle |
| busy_o | output | 1 | Program cycle in progress |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | 8 | Array write data |

## Verification
Requests are sampled on a clock edge. Their effect on the page, offset and loaded bytes is visible from the next cycle onward. `busy_o` goes high one edge after an accepted commit and drops `PROG_CYCLES` edges later. The array write for offset k appears combinationally in busy cycle k and is taken by the array at the edge that ends that cycle.

The bench drives its inputs one time unit after a rising edge. It steps a behavioural model on the same edge and compares `busy_o` and the write port with the model at every falling edge. Array writes seen at a falling edge go into a bench-side memory image, which directed checks read back after each program cycle.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int PAGE_BYTES = 64;
    localparam int OFF_W      = $clog2(PAGE_BYTES);

    typedef logic [OFF_W-1:0] offset_t;
    typedef logic [7:0]       byte_t;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_OPEN,
        ACT_COMMIT,
        ACT_LOAD
    } action_e;

    // One action per idle cycle: open beats commit beats load.
    function automatic action_e arbitrate(input logic busy,
                                          input logic open_req,
                                          input logic commit_req,
                                          input logic load_req,
                                          input logic has_data);
        if (busy)       return ACT_IDLE;
        if (open_req)   return ACT_OPEN;
        if (commit_req) return has_data ? ACT_COMMIT : ACT_IDLE;
        if (load_req)   return ACT_LOAD;
        return ACT_IDLE;
    endfunction

    function automatic offset_t next_offset(input offset_t cur);
        return cur + offset_t'(1);
    endfunction

endpackage

// File: rtl/pcb_store.sv
module pcb_store
    import pcb_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic                    clk,
    input  logic                    rst,
    input  action_e                 act,
    input  logic [ADDR_W-1:0]       open_addr,
    input  byte_t                   load_data,
    input  logic                    clear_i,
    input  offset_t                 rd_idx,
    output byte_t                   rd_data,
    output logic                    rd_loaded,
    output logic [ADDR_W-OFF_W-1:0] page_o,
    output logic                    any_loaded_o
);

    localparam int PAGE_W = ADDR_W - OFF_W;

    logic [PAGE_W-1:0]     page_q;
    offset_t               ptr_q;
    logic [PAGE_BYTES-1:0] loaded;
    byte_t                 lane_data [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            ptr_q  <= '0;
        end else begin
            case (act)
                ACT_OPEN: begin
                    page_q <= open_addr[ADDR_W-1:OFF_W];
                    ptr_q  <= open_addr[OFF_W-1:0];
                end
                ACT_LOAD: ptr_q <= next_offset(ptr_q);
                default:  ;
            endcase
        end
    end

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
        logic  valid_q;
        byte_t data_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= 1'b0;
                data_q  <= '0;
            end else if (clear_i || act == ACT_OPEN) begin
                valid_q <= 1'b0;
            end else if (act == ACT_LOAD && ptr_q == offset_t'(i)) begin
                valid_q <= 1'b1;
                data_q  <= load_data;
            end
        end
        assign loaded[i]    = valid_q;
        assign lane_data[i] = data_q;
    end

    assign rd_data      = lane_data[rd_idx];
    assign rd_loaded    = loaded[rd_idx];
    assign page_o       = page_q;
    assign any_loaded_o = |loaded;

    AST_LOAD_MARKS: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_LOAD) |=> loaded[$past(ptr_q)]); // R3

    AST_OPEN_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_OPEN) |=> !any_loaded_o); // R2

endmodule

// File: rtl/pcb_timer.sv
module pcb_timer
    import pcb_pkg::*;
#(
    parameter int PROG_CYCLES = 100
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    launch_i,
    output logic    busy_o,
    output logic    done_o,
    output logic    scan_live_o,
    output offset_t scan_idx_o
);

    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    initial assert (PROG_CYCLES >= PAGE_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (launch_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end
    end

    assign busy_o      = busy_q;
    assign done_o      = busy_q && (cnt_q == LAST);
    assign scan_live_o = busy_q && (cnt_q < CNT_W'(PAGE_BYTES));
    assign scan_idx_o  = cnt_q[OFF_W-1:0];

    AST_LAUNCH_RAISES: assert property (@(posedge clk) disable iff (rst)
        (launch_i && !busy_o) |=> busy_o); // R5

    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o); // R5

endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer
    import pcb_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int PROG_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_i,
    input  logic [ADDR_W-1:0] open_addr_i,
    input  logic              load_i,
    input  logic [7:0]        load_data_i,
    input  logic              commit_i,
    output logic              busy_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [7:0]        arr_data_o
);

    localparam int PAGE_W = ADDR_W - OFF_W;

    action_e           act;
    logic              any_loaded;
    logic              done;
    logic              scan_live;
    offset_t           scan_idx;
    byte_t             scan_data;
    logic              scan_loaded;
    logic [PAGE_W-1:0] page;

    assign act = arbitrate(busy_o, open_i, commit_i, load_i, any_loaded);

    pcb_store #(.ADDR_W(ADDR_W)) u_store (
        .clk          (clk),
        .rst          (rst),
        .act          (act),
        .open_addr    (open_addr_i),
        .load_data    (load_data_i),
        .clear_i      (done),
        .rd_idx       (scan_idx),
        .rd_data      (scan_data),
        .rd_loaded    (scan_loaded),
        .page_o       (page),
        .any_loaded_o (any_loaded)
    );

    pcb_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .launch_i    (act == ACT_COMMIT),
        .busy_o      (busy_o),
        .done_o      (done),
        .scan_live_o (scan_live),
        .scan_idx_o  (scan_idx)
    );

    assign arr_we_o   = scan_live && scan_loaded;
    assign arr_addr_o = {page, scan_idx};
    assign arr_data_o = scan_data;

    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        arr_we_o |-> busy_o); // R6

    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(commit_i && !open_i)); // R5

    AST_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && commit_i && !any_loaded) |=> !busy_o); // R7

    AST_CLEAR_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> !any_loaded); // R8

    AST_PAGE_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(page)); // R9

endmodule

// File: tb/page_commit_buffer_test.sv
module page_commit_buffer_test;

    localparam int AW   = 14;
    localparam int PROG = 80;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          open_i = 1'b0;
    logic [AW-1:0] open_addr_i = '0;
    logic          load_i = 1'b0;
    logic [7:0]    load_data_i = '0;
    logic          commit_i = 1'b0;
    logic          busy_o;
    logic          arr_we_o;
    logic [AW-1:0] arr_addr_o;
    logic [7:0]    arr_data_o;

    page_commit_buffer #(.ADDR_W(AW), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst(rst), .open_i(open_i), .open_addr_i(open_addr_i),
        .load_i(load_i), .load_data_i(load_data_i), .commit_i(commit_i),
        .busy_o(busy_o), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
        .arr_data_o(arr_data_o)
    );

    always #5 clk = ~clk;

    int nchecks = 0;
    int nfail   = 0;
    int wcount  = 0;
    int cycles  = 0;
    bit finished = 0;
    logic [7:0] ram [int];

    // behavioural reference state
    bit m_busy = 0;
    int m_cnt  = 0;
    int m_page = 0;
    int m_off  = 0;
    bit m_mask [64];
    int m_data [64];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int rd(input int a);
        return ram.exists(a) ? int'(ram[a]) : -1;
    endfunction

    function automatic bit any_mask();
        foreach (m_mask[i]) if (m_mask[i]) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_page = 0; m_off = 0;
            foreach (m_mask[i]) begin m_mask[i] = 0; m_data[i] = 0; end
        end else if (m_busy) begin
            if (m_cnt == PROG - 1) begin
                m_busy = 0; m_cnt = 0;
                foreach (m_mask[i]) m_mask[i] = 0;
            end else m_cnt++;
        end else if (open_i) begin
            m_page = int'(open_addr_i) / 64;
            m_off  = int'(open_addr_i) % 64;
            foreach (m_mask[i]) m_mask[i] = 0;
        end else if (commit_i) begin
            if (any_mask()) begin m_busy = 1; m_cnt = 0; end
        end else if (load_i) begin
            m_data[m_off] = int'(load_data_i);
            m_mask[m_off] = 1;
            m_off = (m_off + 1) % 64;
        end
    end

    always @(negedge clk) begin
        bit exp_we;
        exp_we = m_busy && m_cnt < 64 && m_mask[m_cnt % 64];
        check(busy_o == m_busy, "R5 busy vs model", int'(busy_o), int'(m_busy));
        check(arr_we_o == exp_we, "R6 write enable vs model", int'(arr_we_o), int'(exp_we));
        if (exp_we && arr_we_o) begin
            check(int'(arr_addr_o) == m_page * 64 + m_cnt, "R6 write address",
                  int'(arr_addr_o), m_page * 64 + m_cnt);
            check(int'(arr_data_o) == m_data[m_cnt], "R6 write data",
                  int'(arr_data_o), m_data[m_cnt]);
        end
        if (arr_we_o) begin
            ram[int'(arr_addr_o)] = arr_data_o;
            wcount++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            nchecks++; nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

    task automatic drive(input bit op, input int addr, input bit ld, input int d, input bit cm);
        open_i = op; open_addr_i = AW'(addr); load_i = ld; load_data_i = 8'(d); commit_i = cm;
        @(posedge clk); #1;
        open_i = 0; load_i = 0; commit_i = 0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 1000 && busy_o; k++) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (busy_o) n++; else break;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        int n;
        int w0;
        repeat (3) @(posedge clk);
        #1;
        check(busy_o == 0, "R1 busy in reset", int'(busy_o), 0);
        check(arr_we_o == 0, "R1 write in reset", int'(arr_we_o), 0);
        rst = 0;
        @(negedge clk);
        check(busy_o == 0, "R1 busy after reset", int'(busy_o), 0);
        @(posedge clk); #1;

        // R2 R3 R5 R6: short transaction mid-page
        drive(1, 'h0105, 0, 0, 0);
        drive(0, 0, 1, 'hA0, 0);
        drive(0, 0, 1, 'hA1, 0);
        drive(0, 0, 1, 'hA2, 0);
        w0 = wcount;
        drive(0, 0, 0, 0, 1);
        count_busy(n);
        check(n == PROG, "R5 busy length", n, PROG);
        check(wcount - w0 == 3, "R6 write count", wcount - w0, 3);
        check(rd('h105) == 'hA0, "R3 byte 0", rd('h105), 'hA0);
        check(rd('h106) == 'hA1, "R3 byte 1", rd('h106), 'hA1);
        check(rd('h107) == 'hA2, "R3 byte 2", rd('h107), 'hA2);
        check(rd('h108) == -1, "R6 unloaded offset", rd('h108), -1);

        // R8: second commit with nothing new
        w0 = wcount;
        drive(0, 0, 0, 0, 1);
        repeat (4) begin
            @(negedge clk);
            check(busy_o == 0, "R8 no second cycle", int'(busy_o), 0);
        end
        check(wcount == w0, "R8 no writes", wcount - w0, 0);
        @(posedge clk); #1;

        // R3: offset wraps within the last page, page held
        drive(1, 'h3FFE, 0, 0, 0);
        for (int i = 0; i < 4; i++) drive(0, 0, 1, 16 + i, 0);
        drive(0, 0, 0, 0, 1);
        wait_idle();
        check(rd('h3FFE) == 16, "R3 off 62", rd('h3FFE), 16);
        check(rd('h3FFF) == 17, "R3 off 63", rd('h3FFF), 17);
        check(rd('h3FC0) == 18, "R3 wrap off 0", rd('h3FC0), 18);
        check(rd('h3FC1) == 19, "R3 wrap off 1", rd('h3FC1), 19);
        check(rd('h0000) == -1, "R3 page not advanced", rd('h0000), -1);

        // R4: overfill by two bytes
        drive(1, 'h0200, 0, 0, 0);
        for (int i = 0; i < 66; i++) drive(0, 0, 1, i, 0);
        w0 = wcount;
        drive(0, 0, 0, 0, 1);
        wait_idle();
        check(wcount - w0 == 64, "R4 full page writes", wcount - w0, 64);
        check(rd('h200) == 64, "R4 overwrite off 0", rd('h200), 64);
        check(rd('h201) == 65, "R4 overwrite off 1", rd('h201), 65);
        check(rd('h202) == 2, "R4 kept off 2", rd('h202), 2);
        check(rd('h23F) == 63, "R4 kept off 63", rd('h23F), 63);

        // R9: requests during busy are ignored
        drive(1, 'h0500, 0, 0, 0);
        drive(0, 0, 1, 'h99, 0);
        drive(0, 0, 0, 0, 1);
        drive(1, 'h0600, 0, 0, 0);
        drive(0, 0, 1, 'h42, 0);
        drive(0, 0, 0, 0, 1);
        wait_idle();
        w0 = wcount;
        drive(0, 0, 0, 0, 1);
        @(negedge clk);
        check(busy_o == 0, "R9 ignored load not kept", int'(busy_o), 0);
        @(posedge clk); #1;
        drive(0, 0, 1, 'h33, 0);
        drive(0, 0, 0, 0, 1);
        wait_idle();
        check(rd('h500) == 'h99, "R9 first byte", rd('h500), 'h99);
        check(rd('h501) == 'h33, "R9 page and offset kept", rd('h501), 'h33);
        check(rd('h600) == -1, "R9 ignored open", rd('h600), -1);
        check(wcount - w0 == 1, "R9 write count", wcount - w0, 1);

        // R7: empty commit after open
        w0 = wcount;
        drive(1, 'h0700, 0, 0, 0);
        drive(0, 0, 0, 0, 1);
        repeat (3) begin
            @(negedge clk);
            check(busy_o == 0, "R7 empty commit", int'(busy_o), 0);
        end
        check(wcount == w0, "R7 no writes", wcount - w0, 0);
        @(posedge clk); #1;

        // R10: coinciding requests
        drive(1, 'h0400, 1, 'h55, 0);
        drive(0, 0, 1, 'h11, 0);
        w0 = wcount;
        drive(0, 0, 1, 'h77, 1);
        wait_idle();
        check(rd('h400) == 'h11, "R10 open beats load", rd('h400), 'h11);
        check(rd('h401) == -1, "R10 commit beats load", rd('h401), -1);
        check(wcount - w0 == 1, "R10 write count", wcount - w0, 1);

        repeat (3) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

endmodule